// File: doc/BRIEF.md
# Pipeline token occupancy zero detector

This block watches a single-input, single-output pipeline from its two ends and tells the power-control logic when nothing is left inside it. Each token that enters raises the occupancy by one and each token that leaves lowers it by one. The pipeline is reported empty when the occupancy is zero and no counter update is still in progress.

The occupancy is split over two independent lanes. Successive entry events are steered to lane 0, lane 1, lane 0 and so on, and successive exit events are steered the same way. Each lane stores its count as a chain of one-bit cells. A cell that carries or borrows hands the command to the cell above it one clock later. Every cell below the top keeps a flag saying whether all cells above it are zero. The cell that ends the update sends the new value of that flag down to its lower neighbour. As a result, a lane's zero status depends only on its lowest cell, whatever the width of the count. While a lane is still passing a carry up its chain, any handshake aimed at that lane is held off.

Top module: `tok_occ_zdet`

## Requirements
- R1: After reset, `empty` is 1, both ready outputs are 1 and `err_underflow` is 0. An accepted entry raises the occupancy by one and an accepted exit lowers it by one.
- R2: An entry and an exit accepted in the same cycle that target the same lane cancel out. Neither lane changes, neither lane becomes busy, and `empty` keeps its value.
- R3: `empty` is 1 exactly when both lane counts are zero and neither lane is passing a carry or borrow.
- R4: When a lane is idle, the sticky flag of every cell other than the top one is 1 exactly when all higher cells of that lane hold 0. The lane's zero status is read from its lowest cell alone.
- R5: A carry or borrow moves up one cell per clock. An increment at a lane count with t trailing one bits (for a decrement, t trailing zero bits) keeps that lane busy for min(t, CNT_W-1) cycles after the accepting edge.
- R6: The k-th accepted entry, counting from 0 after reset, goes to lane k mod 2. The k-th applied exit goes to lane k mod 2. Both lanes must read zero for `empty`.
- R7: `ent_ready` is 1 exactly when the lane that the next entry targets is not busy, and `ext_ready` likewise for the next exit. Neither ready output depends on the valid inputs.
- R8: An exit accepted while the occupancy is zero, with no entry cancelling it, raises `err_underflow` for one cycle after the accepting edge. No count changes and the exit steering does not advance.
- R9: Each lane holds up to 2^CNT_W-1 tokens, so the pair tracks up to 2*(2^CNT_W-1) tokens and drains back to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ent_valid | input | 1 | A token enters the pipeline this cycle |
| ent_ready | output | 1 | An entry can be accepted this cycle |
| ext_valid | input | 1 | A token leaves the pipeline this cycle |
| ext_ready | output | 1 | An exit can be accepted this cycle |
| empty | output | 1 | Occupancy is zero and both lanes are settled |
| err_underflow | output | 1 | One-cycle pulse: an exit arrived at zero occupancy and was dropped |

## Verification
The count is exercised with four kinds of stimulus. Runs of entries only build counts with long carry chains, which exposes stall timing and alternation between the lanes. Runs of exits only drain those counts through borrow chains, which shows whether the sticky flags return `empty` at the right cycle. Simultaneous entry and exit at zero occupancy separate true cancellation from two separate updates. A long pseudo-random mix, compared every cycle against a behavioural model of both lanes, shows that stalls, steering and cancellation stay consistent with one another. Underflow and a fill to the full capacity cover the two extremes of the count.

// File: rtl/tozd_pkg.sv
package tozd_pkg;
  localparam int unsigned NLANE = 2;
  localparam int unsigned PTR_W = 1;

  typedef logic [NLANE-1:0] lane_vec_t;

  typedef enum logic {
    OP_INC = 1'b0,
    OP_DEC = 1'b1
  } op_e;
endpackage

// File: rtl/tozd_bit_cell.sv
// One bit of a lane's count plus its sticky flag (all higher bits zero).
module tozd_bit_cell
  import tozd_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  op_e  op_i,
  input  logic ret_vld_i,
  input  logic ret_sz_i,
  output logic val_o,
  output logic sz_o,
  output logic fwd_o,
  output logic ret_vld_o,
  output logic ret_sz_o
);
  logic val_q, val_d;
  logic fwd_q, fwd_d;
  logic carry;

  // A carry leaves this cell on an increment of 1 or a decrement of 0.
  always_comb begin
    carry = (op_i == OP_DEC) ? ~val_q : val_q;
    val_d = act_i ? ~val_q : val_q;
    fwd_d = act_i & carry & ~IS_TOP;
  end

  // The lower neighbour's sticky flag: zero when this cell forwards
  // (a one will remain above it), otherwise this cell's new state.
  assign ret_vld_o = act_i;
  assign ret_sz_o  = (op_i == OP_DEC) & ~carry & sz_o;
  assign val_o     = val_q;
  assign fwd_o     = fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      val_q <= val_d;
      fwd_q <= fwd_d;
    end
  end

  generate
    if (IS_TOP) begin : g_top
      logic unused_ret;
      assign unused_ret = ret_vld_i ^ ret_sz_i;
      assign sz_o = 1'b1;
    end else begin : g_mid
      logic sz_q, sz_d;
      always_comb begin
        sz_d = ret_vld_i ? ret_sz_i : sz_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sz_q <= 1'b1;
        else        sz_q <= sz_d;
      end
      assign sz_o = sz_q;
    end
  endgenerate
endmodule

// File: rtl/tozd_lane.sv
// One interleaved counter: a chain of bit cells, one command in flight.
module tozd_lane
  import tozd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  op_e  op_i,
  output logic zero_o,
  output logic busy_o
);
  localparam int unsigned TOP = CNT_W - 1;

  logic [CNT_W-1:0] val, sz, fwd, ret_vld, ret_sz;
  op_e op_q, op_d;

  always_comb begin
    op_d = start_i ? op_i : op_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_INC;
    else        op_q <= op_d;
  end

  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_cell
      logic act, rv_in, rs_in;
      op_e  op_c;
      if (i == 0) begin : g_lo
        assign act  = start_i;
        assign op_c = op_i;
      end else begin : g_hi
        assign act  = fwd[i-1];
        assign op_c = op_q;
      end
      if (i == TOP) begin : g_cap
        assign rv_in = 1'b0;
        assign rs_in = 1'b0;
      end else begin : g_link
        assign rv_in = ret_vld[i+1];
        assign rs_in = ret_sz[i+1];
      end
      tozd_bit_cell #(.IS_TOP(i == TOP)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .op_i     (op_c),
        .ret_vld_i(rv_in),
        .ret_sz_i (rs_in),
        .val_o    (val[i]),
        .sz_o     (sz[i]),
        .fwd_o    (fwd[i]),
        .ret_vld_o(ret_vld[i]),
        .ret_sz_o (ret_sz[i])
      );
    end
  endgenerate

  assign busy_o = |fwd;
  assign zero_o = ~val[0] & sz[0];

  logic unused_obs;
  assign unused_obs = ^{ret_vld[0], ret_sz[0], val, sz};

  // R5: only one carry front moves through the chain at a time
  a_r5_single_front: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd));

  // R7: a command is only started on an idle lane
  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

  generate
    for (genvar i = 0; i < TOP; i++) begin : g_chk
      // R4: sticky flag matches the higher bits once the lane is idle
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sz[i] == ~|val[TOP:i+1]));
    end
  endgenerate
endmodule

// File: rtl/tozd_steer.sv
// Lane steering, stall handshake, cancellation and underflow detection.
module tozd_steer
  import tozd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ent_valid_i,
  input  logic      ext_valid_i,
  input  lane_vec_t busy_i,
  input  lane_vec_t zero_i,
  output logic      ent_ready_o,
  output logic      ext_ready_o,
  output lane_vec_t start_o,
  output lane_vec_t dec_o,
  output logic      err_o
);
  logic [PTR_W-1:0] ent_ptr_q, ent_ptr_d, ext_ptr_q, ext_ptr_d;
  logic err_q, err_d;
  logic acc_e, acc_x, cancel, uflow;

  always_comb begin
    ent_ready_o = ~busy_i[ent_ptr_q];
    ext_ready_o = ~busy_i[ext_ptr_q];
    acc_e  = ent_valid_i & ent_ready_o;
    acc_x  = ext_valid_i & ext_ready_o;
    cancel = acc_e & acc_x & (ent_ptr_q == ext_ptr_q);
    uflow  = acc_x & ~cancel & zero_i[ext_ptr_q];
    ent_ptr_d = acc_e ? ent_ptr_q + 1'b1 : ent_ptr_q;
    ext_ptr_d = (acc_x & ~uflow) ? ext_ptr_q + 1'b1 : ext_ptr_q;
    err_d = uflow;
  end

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_sel
      logic hit_e, hit_x;
      assign hit_e = acc_e & (ent_ptr_q == PTR_W'(l));
      assign hit_x = acc_x & ~uflow & (ext_ptr_q == PTR_W'(l));
      assign start_o[l] = ~cancel & (hit_e | hit_x);
      assign dec_o[l]   = ~cancel & hit_x;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_ptr_q <= '0;
      ext_ptr_q <= '0;
      err_q     <= 1'b0;
    end else begin
      ent_ptr_q <= ent_ptr_d;
      ext_ptr_q <= ext_ptr_d;
      err_q     <= err_d;
    end
  end

  assign err_o = err_q;

  // R6: every accepted entry moves the entry steering to the other lane
  a_r6_ent_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid_i && ent_ready_o) |=> (ent_ptr_q != $past(ent_ptr_q)));

  // R8: a dropped exit leaves the exit steering where it was
  a_r8_uflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (ext_ptr_q == $past(ext_ptr_q)));
endmodule

// File: rtl/tok_occ_zdet.sv
module tok_occ_zdet
  import tozd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ent_valid,
  output logic ent_ready,
  input  logic ext_valid,
  output logic ext_ready,
  output logic empty,
  output logic err_underflow
);
  logic rst_q1, rst_q2, rst_n_int;
  lane_vec_t busy, zero, start, dec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_n_int = rst_q2;

  tozd_steer u_steer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .ent_valid_i(ent_valid),
    .ext_valid_i(ext_valid),
    .busy_i     (busy),
    .zero_i     (zero),
    .ent_ready_o(ent_ready),
    .ext_ready_o(ext_ready),
    .start_o    (start),
    .dec_o      (dec),
    .err_o      (err_underflow)
  );

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      tozd_lane #(.CNT_W(CNT_W)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .start_i(start[l]),
        .op_i   (dec[l] ? OP_DEC : OP_INC),
        .zero_o (zero[l]),
        .busy_o (busy[l])
      );
    end
  endgenerate

  assign empty = (&zero) & ~(|busy);

  // R1: a lone accepted entry leaves the pipeline non-empty
  a_r1_entry_nonempty: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ent_valid && ent_ready && !(ext_valid && ext_ready)) |=> !empty);

  // R2: entry and exit together at zero occupancy cancel
  a_r2_cancel_keep: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ent_valid && ent_ready && ext_valid && ext_ready && empty) |=> empty);

  // R8: the underflow pulse only follows an exit at an empty pipeline
  a_r8_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n_int)
    err_underflow |-> $past(ext_valid && ext_ready && empty && !ent_valid));
endmodule

// File: tb/tok_occ_zdet_tb_top.sv
module tok_occ_zdet_tb_top;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ent_valid, ext_valid;
  logic ent_ready, ext_ready, empty, err_underflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int cnt[2];
  int bsy[2];
  int ep, xp;
  bit m_err;

  always #10 clk = ~clk;

  tok_occ_zdet #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ext_valid(ext_valid), .ext_ready(ext_ready),
    .empty(empty), .err_underflow(err_underflow)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic int run_len(input int v, input bit dec);
    int n = 0;
    while (n < CW - 1 && (((v >> n) & 1) == (dec ? 0 : 1))) n++;
    return n;
  endfunction

  function automatic logic m_empty();
    return (cnt[0] == 0 && cnt[1] == 0 && bsy[0] == 0 && bsy[1] == 0);
  endfunction

  function automatic int total();
    return cnt[0] + cnt[1];
  endfunction

  task automatic compare_as(input string req);
    check(req, "empty", empty, m_empty());
    check(req, "ent_ready", ent_ready, bsy[ep] == 0);
    check(req, "ext_ready", ext_ready, bsy[xp] == 0);
    check(req, "err_underflow", err_underflow, m_err);
  endtask

  task automatic advance(input logic ev, input logic xv);
    int nb[2];
    bit ae, ax;
    for (int l = 0; l < 2; l++) nb[l] = (bsy[l] > 0) ? bsy[l] - 1 : 0;
    ae = ev && (bsy[ep] == 0);
    ax = xv && (bsy[xp] == 0);
    m_err = 1'b0;
    if (ae && ax && ep == xp) begin
      ep ^= 1;
      xp ^= 1;
    end else begin
      if (ae) begin
        nb[ep]  = run_len(cnt[ep], 1'b0);
        cnt[ep] = (cnt[ep] + 1) % (1 << CW);
        ep ^= 1;
      end
      if (ax) begin
        if (cnt[xp] == 0) m_err = 1'b1;
        else begin
          nb[xp] = run_len(cnt[xp], 1'b1);
          cnt[xp]--;
          xp ^= 1;
        end
      end
    end
    bsy[0] = nb[0];
    bsy[1] = nb[1];
  endtask

  // called at a falling edge: compare, drive, update model, wait
  task automatic step(input logic ev, input logic xv);
    compare_as("R1/R3/R5/R7/R8");
    ent_valid = ev;
    ext_valid = xv;
    advance(ev, xv);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int g = 0; g < 200 && (total() > 0 || !m_empty()); g++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    cnt[0] = 0; cnt[1] = 0; bsy[0] = 0; bsy[1] = 0;
    ep = 0; xp = 0; m_err = 1'b0;
    rst_n = 1'b0;
    ent_valid = 1'b0;
    ext_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "empty in reset", empty, 1'b1);
    check("R1", "ent_ready in reset", ent_ready, 1'b1);
    check("R1", "ext_ready in reset", ext_ready, 1'b1);
    check("R1", "err in reset", err_underflow, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0);

    // R6: three entries, the third lands on lane 0 and stalls exits only
    repeat (3) step(1'b1, 1'b0);
    compare_as("R6");
    check("R6", "ext_ready lane0 busy", ext_ready, 1'b0);
    check("R6", "ent_ready lane1 idle", ent_ready, 1'b1);
    step(1'b0, 1'b0);

    // R5: a run of entries creates multi-cell carries and stalls
    repeat (9) step(1'b1, 1'b0);
    compare_as("R5");
    check("R5", "not empty", empty, 1'b0);

    // R4: drain through borrow chains back to empty
    drain();
    compare_as("R4");
    check("R4", "empty after drain", empty, 1'b1);

    // R2: simultaneous entry and exit at zero occupancy cancel
    repeat (5) step(1'b1, 1'b1);
    compare_as("R2");
    check("R2", "empty kept", empty, 1'b1);

    // R8: exit at zero is flagged and ignored
    step(1'b0, 1'b1);
    compare_as("R8");
    check("R8", "underflow pulse", err_underflow, 1'b1);
    step(1'b0, 1'b0);
    check("R8", "pulse one cycle", err_underflow, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    compare_as("R8");
    check("R8", "empty after balanced pair", empty, 1'b1);

    // R9: fill to full capacity, then drain
    for (int g = 0; g < 400 && total() < 2 * ((1 << CW) - 1); g++)
      step(total() < 2 * ((1 << CW) - 1), 1'b0);
    step(1'b0, 1'b0);
    compare_as("R9");
    check("R9", "full not empty", empty, 1'b0);
    drain();
    compare_as("R9");
    check("R9", "empty after full drain", empty, 1'b1);

    // R3: pseudo-random mix against the model
    lfsr = 32'hACE1_2B5D;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3] && (total() < 20), lfsr[9] | (lfsr[14] & lfsr[5]));
    end
    drain();
    compare_as("R3");
    check("R3", "empty at end", empty, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule